// File: doc/BRIEF.md
# Zero-Address Stack Expression Engine

This block is a compact stack-organized execution unit. It accepts one instruction at a time over a valid/ready handshake and runs it against a synchronous, word-addressed data memory. Only two instructions carry a memory address. The load instruction reads a word and places it on an internal hardware stack. The store instruction writes the top word out and removes it. The arithmetic instructions carry no operand field. They take the two topmost stack entries and leave a single result on the top.

A host evaluates an arithmetic expression by issuing it in postfix order. For example, load A, load B, add, load C, load D, add, multiply, store X leaves (A+B)*(C+D) at X. Misuse sets one of two sticky flags and leaves the stack as it was. The misuse cases are a load into a full stack, or a store or arithmetic instruction with too few entries. Stack depth, word width and address width are parameters. A parameter also selects between two multiplier structures.

Top module: `stack_expr_engine`

## Requirements
- R1: An instruction word is 16 bits: the opcode in bits [15:12] and the memory address in bits [11:0]. The codes are 0001 load-to-stack (PUSH), 0010 store-from-stack (POP), 0011 ADD and 0100 MUL. The address field is driven on mem_addr while the instruction is offered.
- R2: PUSH reads the memory word at its address and places it on top of the stack. It takes two cycles: the accept cycle and one load cycle. During the load cycle busy is 1 and instr_ready is 0.
- R3: POP writes the top-of-stack word to its address. mem_we is high for exactly the accept cycle, and the entry is removed from the stack.
- R4: ADD removes the two top entries and pushes their sum modulo 2^16.
- R5: MUL removes the two top entries and pushes the low 16 bits of their product.
- R6: The postfix sequence PUSH A, PUSH B, ADD, PUSH C, PUSH D, ADD, MUL, POP X stores ((A+B)*(C+D)) mod 2^16 at X.
- R7: A PUSH while the stack holds 8 entries sets the sticky overflow flag. It leaves all stack contents unchanged.
- R8: POP on an empty stack, or ADD or MUL with fewer than two entries, sets the sticky underflow flag. It leaves the stack unchanged and performs no memory write.
- R9: A synchronous active-high reset empties the stack, clears both flags and returns the block to ready.
- R10: Any other opcode is accepted in one cycle and has no effect on the stack, the flags or memory.
- R11: Entries leave the stack in last-in, first-out order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction offered |
| instr_ready | output | 1 | Block can accept an instruction this cycle |
| instr_word | input | 16 | Opcode [15:12] and address [11:0] |
| mem_addr | output | 12 | Data memory address |
| mem_we | output | 1 | Data memory write enable |
| mem_wdata | output | 16 | Data memory write word |
| mem_rdata | input | 16 | Data memory read word, valid the cycle after the address |
| busy | output | 1 | Multi-cycle instruction in progress |
| ovf_err | output | 1 | Sticky stack overflow flag |
| unf_err | output | 1 | Sticky stack underflow flag |

## Verification
The hardest situation to reach from the ports is an error that happens on a stack holding data. From outside, that stack should look exactly as it did before the rejected instruction. The stimulus fills all eight slots with distinct values and then offers a ninth load. It drains every slot to separate addresses, so each position is checked in LIFO order. A last store then confirms that exactly eight entries were kept. Arithmetic is swept over all pairs from a sixteen-value set that includes zero, one, all-ones and the sign-bit boundaries. The expected sums and truncated products are computed in the bench.

// File: rtl/sxe_pkg.sv
package sxe_pkg;
   localparam int OPC_W = 4;

   typedef enum logic [OPC_W-1:0] {
      OPC_PUSH = 4'b0001,
      OPC_POP  = 4'b0010,
      OPC_ADD  = 4'b0011,
      OPC_MUL  = 4'b0100
   } sxe_opc_e;

   typedef enum logic [2:0] {
      K_NONE,
      K_PUSH,
      K_POP,
      K_ADD,
      K_MUL
   } sxe_kind_e;

   typedef enum logic {
      ST_IDLE,
      ST_LOAD
   } sxe_state_e;
endpackage

// File: rtl/sxe_decode.sv
module sxe_decode
   import sxe_pkg::*;
#(
   parameter int ADDR_W = 12,
   localparam int WORD_W = OPC_W + ADDR_W
) (
   input  logic [WORD_W-1:0] word,
   output sxe_kind_e         kind,
   output logic [ADDR_W-1:0] addr
);
   logic [OPC_W-1:0] opc;

   assign opc  = word[WORD_W-1 -: OPC_W];
   assign addr = word[ADDR_W-1:0];

   always_comb begin
      case (opc)
         OPC_PUSH: kind = K_PUSH;
         OPC_POP:  kind = K_POP;
         OPC_ADD:  kind = K_ADD;
         OPC_MUL:  kind = K_MUL;
         default:  kind = K_NONE;
      endcase
   end
endmodule

// File: rtl/sxe_alu.sv
module sxe_alu #(
   parameter int DATA_W    = 16,
   parameter int MUL_STYLE = 0
) (
   input  logic [DATA_W-1:0] lhs,
   input  logic [DATA_W-1:0] rhs,
   input  logic              sel_mul,
   output logic [DATA_W-1:0] res
);
   logic [DATA_W-1:0] sum;
   logic [DATA_W-1:0] prod;

   assign sum = lhs + rhs;

   generate
      if (MUL_STYLE == 0) begin : g_mul_direct
         logic [2*DATA_W-1:0] full;
         assign full = lhs * rhs;
         assign prod = full[DATA_W-1:0];
      end else begin : g_mul_shift_add
         always_comb begin
            logic [DATA_W-1:0] acc;
            acc = '0;
            for (int i = 0; i < DATA_W; i++) begin
               if (rhs[i]) acc = acc + (lhs << i);
            end
            prod = acc;
         end
      end
   endgenerate

   assign res = sel_mul ? prod : sum;
endmodule

// File: rtl/sxe_stack.sv
module sxe_stack #(
   parameter int DATA_W = 16,
   parameter int DEPTH  = 8,
   localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              push_en,
   input  logic [DATA_W-1:0] push_data,
   input  logic              pop_en,
   input  logic              merge_en,
   input  logic [DATA_W-1:0] merge_data,
   output logic [DATA_W-1:0] top,
   output logic [DATA_W-1:0] second,
   output logic              full,
   output logic              empty,
   output logic              has_two
);
   logic [DATA_W-1:0] slot [DEPTH];
   logic [CW-1:0]     cnt;
   logic [IW-1:0]     top_idx;
   logic [IW-1:0]     sec_idx;

   assign top_idx = IW'(cnt - CW'(1));
   assign sec_idx = IW'(cnt - CW'(2));
   assign top     = slot[top_idx];
   assign second  = slot[sec_idx];
   assign full    = (cnt == CW'(DEPTH));
   assign empty   = (cnt == '0);
   assign has_two = (cnt >= CW'(2));

   generate
      for (genvar g = 0; g < DEPTH; g++) begin : g_slot
         always_ff @(posedge clk) begin
            if (rst) begin
               slot[g] <= '0;
            end else if (push_en && (32'(cnt) == g)) begin
               slot[g] <= push_data;
            end else if (merge_en && (32'(cnt) == g + 2)) begin
               slot[g] <= merge_data;
            end
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt <= '0;
      end else if (push_en) begin
         cnt <= cnt + CW'(1);
      end else if (pop_en || merge_en) begin
         cnt <= cnt - CW'(1);
      end
   end

   AST_DEPTH_BOUND: assert property (@(posedge clk) disable iff (rst)
      cnt <= CW'(DEPTH)); // R7
   AST_NO_PUSH_FULL: assert property (@(posedge clk) disable iff (rst)
      push_en |-> !full); // R7
   AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (rst)
      pop_en |-> !empty); // R8
   AST_MERGE_NEEDS_TWO: assert property (@(posedge clk) disable iff (rst)
      merge_en |-> has_two); // R8
   AST_ONE_STACK_OP: assert property (@(posedge clk) disable iff (rst)
      $onehot0({push_en, pop_en, merge_en})); // R11
endmodule

// File: rtl/stack_expr_engine.sv
module stack_expr_engine
   import sxe_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter int ADDR_W    = 12,
   parameter int DEPTH     = 8,
   parameter int MUL_STYLE = 0,
   localparam int WORD_W   = OPC_W + ADDR_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              instr_valid,
   output logic              instr_ready,
   input  logic [WORD_W-1:0] instr_word,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_we,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              busy,
   output logic              ovf_err,
   output logic              unf_err
);
   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("stack_expr_engine: DEPTH must be at least 2");
      end
      if (DATA_W < 2) begin : g_bad_data
         $error("stack_expr_engine: DATA_W must be at least 2");
      end
      if (ADDR_W < 1) begin : g_bad_addr
         $error("stack_expr_engine: ADDR_W must be at least 1");
      end
      if (MUL_STYLE != 0 && MUL_STYLE != 1) begin : g_bad_mul
         $error("stack_expr_engine: MUL_STYLE must be 0 or 1");
      end
   endgenerate

   sxe_kind_e         kind;
   logic [ADDR_W-1:0] dec_addr;
   sxe_state_e        state_q;
   logic              accept;
   logic              is_arith;
   logic              push_go, pop_go, merge_go;
   logic              push_en;
   logic              ovf_hit, unf_hit;
   logic              ovf_q, unf_q;
   logic [DATA_W-1:0] top, second, alu_res;
   logic              full, empty, has_two;

   sxe_decode #(.ADDR_W(ADDR_W)) u_dec (
      .word (instr_word),
      .kind (kind),
      .addr (dec_addr)
   );

   assign instr_ready = (state_q == ST_IDLE);
   assign busy        = (state_q != ST_IDLE);
   assign accept      = instr_valid && instr_ready;
   assign is_arith    = (kind == K_ADD) || (kind == K_MUL);

   assign push_go  = accept && (kind == K_PUSH) && !full;
   assign pop_go   = accept && (kind == K_POP) && !empty;
   assign merge_go = accept && is_arith && has_two;
   assign push_en  = (state_q == ST_LOAD);

   assign ovf_hit = accept && (kind == K_PUSH) && full;
   assign unf_hit = accept && (((kind == K_POP) && empty) || (is_arith && !has_two));

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= ST_IDLE;
      end else begin
         case (state_q)
            ST_IDLE: if (push_go) state_q <= ST_LOAD;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         ovf_q <= 1'b0;
         unf_q <= 1'b0;
      end else begin
         if (ovf_hit) ovf_q <= 1'b1;
         if (unf_hit) unf_q <= 1'b1;
      end
   end

   assign ovf_err = ovf_q;
   assign unf_err = unf_q;

   sxe_alu #(.DATA_W(DATA_W), .MUL_STYLE(MUL_STYLE)) u_alu (
      .lhs     (second),
      .rhs     (top),
      .sel_mul (kind == K_MUL),
      .res     (alu_res)
   );

   sxe_stack #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_stk (
      .clk        (clk),
      .rst        (rst),
      .push_en    (push_en),
      .push_data  (mem_rdata),
      .pop_en     (pop_go),
      .merge_en   (merge_go),
      .merge_data (alu_res),
      .top        (top),
      .second     (second),
      .full       (full),
      .empty      (empty),
      .has_two    (has_two)
   );

   assign mem_addr  = dec_addr;
   assign mem_we    = pop_go;
   assign mem_wdata = top;

   AST_LOAD_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_LOAD) |=> (state_q == ST_IDLE)); // R2
   AST_LOAD_FOLLOWS_PUSH: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_LOAD) |-> $past(accept && kind == K_PUSH)); // R2
   AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (rst)
      busy |-> !instr_ready); // R2
   AST_WRITE_ONLY_IDLE: assert property (@(posedge clk) disable iff (rst)
      mem_we |-> (!busy && instr_valid)); // R3
   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
      ovf_err |=> ovf_err); // R7
   AST_UNF_STICKY: assert property (@(posedge clk) disable iff (rst)
      unf_err |=> unf_err); // R8
   AST_NO_WRITE_ON_UNF: assert property (@(posedge clk) disable iff (rst)
      (accept && kind == K_POP && empty) |-> !mem_we); // R8
endmodule

// File: tb/tb_stack_expr_engine.sv
`timescale 1ns/1ps
module tb_stack_expr_engine;
   localparam logic [3:0] C_PUSH = 4'b0001;
   localparam logic [3:0] C_POP  = 4'b0010;
   localparam logic [3:0] C_ADD  = 4'b0011;
   localparam logic [3:0] C_MUL  = 4'b0100;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        instr_valid = 1'b0;
   logic        instr_ready;
   logic [15:0] instr_word = '0;
   logic [11:0] mem_addr;
   logic        mem_we;
   logic [15:0] mem_wdata;
   logic [15:0] mem_rdata;
   logic        busy, ovf_err, unf_err;

   int total = 0;
   int bad = 0;
   int we_cnt = 0;
   bit done = 0;

   logic [15:0] mem [256];

   always #4 clk = ~clk;

   stack_expr_engine dut (
      .clk(clk), .rst(rst),
      .instr_valid(instr_valid), .instr_ready(instr_ready), .instr_word(instr_word),
      .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .busy(busy), .ovf_err(ovf_err), .unf_err(unf_err)
   );

   always @(posedge clk) begin
      if (mem_we) begin
         mem[mem_addr[7:0]] <= mem_wdata;
         we_cnt <= we_cnt + 1;
      end
      mem_rdata <= mem[mem_addr[7:0]];
   end

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic send(logic [3:0] op, logic [11:0] a);
      @(negedge clk);
      while (!instr_ready) @(negedge clk);
      instr_valid = 1'b1;
      instr_word  = {op, a};
      #1 chk("R1 address field", {20'd0, mem_addr}, {20'd0, a});
      @(negedge clk);
      instr_valid = 1'b0;
   endtask

   task automatic push_val(logic [11:0] a, logic [15:0] v);
      mem[a[7:0]] <= v;
      send(C_PUSH, a);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
   endtask

   function automatic logic [15:0] pick(int i);
      case (i)
         0: return 16'h0000;
         1: return 16'h0001;
         2: return 16'hFFFF;
         3: return 16'h8000;
         4: return 16'h7FFF;
         default: return 16'((i * 32'h3A7) ^ (i << 9));
      endcase
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int w0;
      for (int i = 0; i < 256; i++) mem[i] <= 16'(i * 7);
      repeat (3) @(negedge clk);
      rst = 1'b0;
      // R9 reset state
      chk("R9 ready after reset", {31'd0, instr_ready}, 1);
      chk("R9 busy after reset", {31'd0, busy}, 0);
      chk("R9 ovf after reset", {31'd0, ovf_err}, 0);
      chk("R9 unf after reset", {31'd0, unf_err}, 0);

      // R2 push timing, R3 pop
      push_val(12'd5, 16'h1234);
      chk("R2 busy in load cycle", {31'd0, busy}, 1);
      chk("R2 ready low in load cycle", {31'd0, instr_ready}, 0);
      @(negedge clk);
      chk("R2 busy clears", {31'd0, busy}, 0);
      w0 = we_cnt;
      send(C_POP, 12'd100);
      chk("R3 popped word stored", {16'd0, mem[100]}, 32'h1234);
      chk("R3 one write per pop", we_cnt - w0, 1);
      mem[101] <= 16'hBEEF;
      send(C_POP, 12'd101);
      chk("R8 pop on empty sets unf", {31'd0, unf_err}, 1);
      chk("R8 no write on empty pop", {16'd0, mem[101]}, 32'hBEEF);
      chk("R3 pop removed entry", we_cnt - w0, 1);
      do_reset();
      chk("R9 flags cleared", {30'd0, ovf_err, unf_err}, 0);

      // R4 R5 sweep
      for (int m = 0; m < 2; m++) begin
         for (int i = 0; i < 16; i++) begin
            for (int j = 0; j < 16; j++) begin
               logic [15:0] a, b, e;
               logic [31:0] p;
               a = pick(i);
               b = pick(j);
               p = a * b;
               e = (m == 0) ? 16'(a + b) : p[15:0];
               push_val(12'd10, a);
               push_val(12'd11, b);
               send(m == 0 ? C_ADD : C_MUL, 12'd0);
               send(C_POP, 12'd20);
               if (m == 0) chk("R4 sum", {16'd0, mem[20]}, {16'd0, e});
               else        chk("R5 product", {16'd0, mem[20]}, {16'd0, e});
            end
         end
      end
      chk("R4 no flag during sweep", {30'd0, ovf_err, unf_err}, 0);

      // R6 expression
      for (int k = 0; k < 6; k++) begin
         logic [15:0] va, vb, vc, vd, e;
         va = pick(k + 3); vb = pick(k * 2 + 1); vc = pick(k + 7); vd = pick(15 - k);
         e  = 16'(16'(va + vb) * 16'(vc + vd));
         push_val(12'd30, va);
         push_val(12'd31, vb);
         send(C_ADD, 12'd0);
         push_val(12'd32, vc);
         push_val(12'd33, vd);
         send(C_ADD, 12'd0);
         send(C_MUL, 12'd0);
         send(C_POP, 12'd40);
         chk("R6 expression result", {16'd0, mem[40]}, {16'd0, e});
      end

      // R7 overflow, R11 LIFO
      for (int k = 0; k < 8; k++) push_val(12'(50 + k), 16'(16'hA000 + k * 16'h111));
      chk("R7 no ovf at depth", {31'd0, ovf_err}, 0);
      w0 = we_cnt;
      push_val(12'd58, 16'hDEAD);
      chk("R7 ovf set on full push", {31'd0, ovf_err}, 1);
      chk("R7 no write on full push", we_cnt - w0, 0);
      for (int k = 0; k < 8; k++) begin
         send(C_POP, 12'(60 + k));
         chk("R11 lifo order", {16'd0, mem[60 + k]}, {16'd0, 16'(16'hA000 + (7 - k) * 16'h111)});
      end
      chk("R7 ovf sticky", {31'd0, ovf_err}, 1);
      w0 = we_cnt;
      send(C_POP, 12'd70);
      chk("R7 only eight kept", {31'd0, unf_err}, 1);
      chk("R8 no write after drain", we_cnt - w0, 0);

      // R9 reset empties stack
      do_reset();
      push_val(12'd71, 16'h0101);
      push_val(12'd72, 16'h0202);
      do_reset();
      chk("R9 flags zero", {30'd0, ovf_err, unf_err}, 0);
      w0 = we_cnt;
      send(C_POP, 12'd73);
      chk("R9 stack emptied", {31'd0, unf_err}, 1);
      chk("R9 no write", we_cnt - w0, 0);

      // R8 arithmetic underflow keeps the stack
      do_reset();
      send(C_MUL, 12'd0);
      chk("R8 mul on empty", {31'd0, unf_err}, 1);
      push_val(12'd74, 16'h0055);
      send(C_ADD, 12'd0);
      send(C_POP, 12'd75);
      chk("R8 single entry kept", {16'd0, mem[75]}, 32'h0055);

      // R10 unknown opcodes
      do_reset();
      push_val(12'd76, 16'h0077);
      w0 = we_cnt;
      send(4'b0000, 12'd80);
      chk("R10 one-cycle accept", {31'd0, instr_ready}, 1);
      send(4'b1111, 12'd81);
      send(4'b0101, 12'd82);
      chk("R10 no write", we_cnt - w0, 0);
      chk("R10 no flags", {30'd0, ovf_err, unf_err}, 0);
      send(C_POP, 12'd83);
      chk("R10 top unchanged", {16'd0, mem[83]}, 32'h0077);
      send(C_POP, 12'd84);
      chk("R10 depth unchanged", {31'd0, unf_err}, 1);

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule